// File: doc/BRIEF.md
# Command-Style Board Control Register

This block is the main 32-bit control and status word that a host uses to steer a network interface board. Almost every writable bit is a command: writing a 1 performs an action and writing a 0 does nothing. Software can therefore issue exactly one command per write without reading the register first or repeating bits to keep the current state. Pairs of command bits set and clear one held level each: run or reset for the local processor, for the expansion bus and for the whole board, and an interrupt enable. Four further command bits produce single-cycle DMA trigger pulses.

Two command bits force the host bus width to 64 or 32 bits. A read-only flag reports whether a correct 64-bit power-up sequence was seen. Only the low five bits form an ordinary stored field, holding the doorbell configuration: limit checking, multi-queue and a 3-bit queue size. The register is little-endian and honours per-byte write enables. A byte-wide write can therefore change the command bytes without disturbing the stored field.

Top module: `board_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset the processor, expansion bus and board are held in reset (run levels 0), interrupts are disabled, both force levels are 0, the configuration field is 0, no trigger pulse is active, and the read word is 0x55000000 with bit 14 added when the detected flag is high.
- R2: Within byte lane 3, writing 1 to bit 31/29/27/25 sets the processor run, bus run, board run and interrupt-enable level respectively. Writing 1 to bit 30/28/26/24 clears that level. On read, the upper bit of each pair shows the level and the lower bit shows its complement.
- R3: When one write carries both bits of a pair, the clearing (hold or disable) bit wins.
- R4: Writing 0 to any command bit leaves every held level unchanged.
- R5: Writing 1 to bit 20+k in lane 2 (k = 0..3) drives trigger output k high for exactly the one cycle after the write edge. Bits 23..20 read as 0.
- R6: Bit 14 reads the detected-sequence input directly. Bits 13..9, bit 5 and every other unlisted bit read as 0, and writes to them have no effect.
- R7: Writing 1 to bit 7 sets force-64 and clears force-32. Writing 1 to bit 6 sets force-32 and clears force-64. When both are written at once, force-32 wins. Bits 7 and 6 read back the force-64 and force-32 levels.
- R8: A write with byte enable 0 asserted overwrites bits 4..0 with the written value, zeros included.
- R9: A bit whose byte lane is not enabled in a write is ignored (lane n covers bits 8n+7..8n).
- R10: Held levels and the read word reflect a write in the cycle right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_be | input | 4 | Byte enables, bit n covers data bits 8n+7..8n |
| wr_data | input | 32 | Write data |
| width_ok_in | input | 1 | Correct 64-bit power-up sequence was detected |
| rd_data | output | 32 | Read word |
| proc_run | output | 1 | Local processor released from reset |
| bus_run | output | 1 | Expansion bus released from reset |
| board_run | output | 1 | Board released from reset |
| irq_en | output | 1 | Interrupts enabled |
| dma_kick | output | 4 | One-cycle DMA trigger pulses, bit k for channel k |
| force64 | output | 1 | Forcing 64-bit mode |
| force32 | output | 1 | Forcing 32-bit mode |
| dbell_cfg | output | 5 | Doorbell configuration field |

## Verification
Every held level, force level, configuration bit and the read word is due one clock edge after the write edge. The read word is a combinational view of those registers, except bit 14, which follows its input at once. A trigger pulse is high only in the cycle after the write edge and low again one edge later. The bench drives each write at a falling edge and checks all outputs at the next falling edge. It then checks the trigger outputs again one cycle later, so each sample lands mid-cycle, after the register that produces the result.

// File: rtl/board_ctl_pkg.sv
// Package: bit positions and widths of the board control word.
// Assumes a 32-bit little-endian word split into four byte lanes.
package board_ctl_pkg;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int NUM_PAIRS = 4;   // 0 proc, 1 bus, 2 board, 3 irq
    localparam int PAIR_TOP  = 31;  // set bit of pair 0
    localparam int NUM_DMA   = 4;
    localparam int DMA_LSB   = 20;
    localparam int WIDTH_BIT = 14;
    localparam int F64_BIT   = 7;
    localparam int F32_BIT   = 6;
    localparam int CFG_W     = 5;

    // Set (run/enable) bit position of pair k.
    function automatic int set_pos(input int k);
        return PAIR_TOP - 2 * k;
    endfunction

    // Clear (hold/disable) bit position of pair k.
    function automatic int clr_pos(input int k);
        return PAIR_TOP - 2 * k - 1;
    endfunction
endpackage

// File: rtl/bctl_pair_cell.sv
// One held level driven by a write-one set command and a write-one clear
// command. Assumes the commands are already qualified by strobe and lane.
module bctl_pair_cell #(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    output logic level
);
    // Hold the level; clear beats set when both arrive together.
    always_ff @(posedge clk) begin
        if (!rst_n)       level <= RESET_VAL;
        else if (clr_cmd) level <= 1'b0;
        else if (set_cmd) level <= 1'b1;
    end

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> !level);
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cmd && !clr_cmd) |=> level);
    a_r4_no_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_cmd || clr_cmd) |=> $stable(level));
endmodule

// File: rtl/bctl_pulse_gen.sv
// Registered single-cycle pulses, one per channel.
// Assumes each fire bit is already qualified by strobe and lane.
module bctl_pulse_gen #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    output logic [N-1:0] pulse
);
    // Each pulse lasts for the cycle after its fire request.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= fire;
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse[k] && !fire[k]) |=> !pulse[k]);
        a_r5_fire_pulses: assert property (@(posedge clk) disable iff (!rst_n)
            fire[k] |=> pulse[k]);
    end
endmodule

// File: rtl/bctl_cfg_field.sv
// Plain stored field that is overwritten by every enabled write.
// Assumes the write enable is already qualified by strobe and lane.
module bctl_cfg_field #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Destructive overwrite of the whole field.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= din;
    end

    a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(din)));
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
endmodule

// File: rtl/board_ctl_reg.sv
// Board control and status word. It decodes write-one commands per byte
// lane, holds the run and enable levels, emits DMA trigger pulses, keeps
// the force-width levels and the doorbell configuration field, and forms
// the read word. Assumes a single-cycle write strobe and a synchronous
// active-low reset.
module board_ctl_reg
    import board_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LANES-1:0]   wr_be,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               width_ok_in,
    output logic [WORD_W-1:0]  rd_data,
    output logic               proc_run,
    output logic               bus_run,
    output logic               board_run,
    output logic               irq_en,
    output logic [NUM_DMA-1:0] dma_kick,
    output logic               force64,
    output logic               force32,
    output logic [CFG_W-1:0]   dbell_cfg
);
    logic [WORD_W-1:0]    bit_wr;   // data bits qualified by strobe and lane
    logic [NUM_PAIRS-1:0] run_lvl;
    logic                 f64_q, f32_q;

    // Qualify each data bit by the strobe and its lane enable.
    always_comb begin
        for (int i = 0; i < WORD_W; i++)
            bit_wr[i] = wr_en & wr_be[i / 8] & wr_data[i];
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        bctl_pair_cell #(.RESET_VAL(1'b0)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_cmd (bit_wr[set_pos(k)]),
            .clr_cmd (bit_wr[clr_pos(k)]),
            .level   (run_lvl[k])
        );
    end

    bctl_pulse_gen #(.N(NUM_DMA)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (bit_wr[DMA_LSB +: NUM_DMA]),
        .pulse (dma_kick)
    );

    bctl_cfg_field #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en & wr_be[0]),
        .din   (wr_data[CFG_W-1:0]),
        .q     (dbell_cfg)
    );

    // Force-width levels: the two are exclusive and the 32-bit command wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f64_q <= 1'b0;
            f32_q <= 1'b0;
        end else if (bit_wr[F32_BIT]) begin
            f64_q <= 1'b0;
            f32_q <= 1'b1;
        end else if (bit_wr[F64_BIT]) begin
            f64_q <= 1'b1;
            f32_q <= 1'b0;
        end
    end

    // Read word: pair levels with complements, status flag, force levels,
    // stored field; every other bit reads zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            rd_data[set_pos(k)] = run_lvl[k];
            rd_data[clr_pos(k)] = ~run_lvl[k];
        end
        rd_data[WIDTH_BIT]   = width_ok_in;
        rd_data[F64_BIT]     = f64_q;
        rd_data[F32_BIT]     = f32_q;
        rd_data[CFG_W-1:0]   = dbell_cfg;
    end

    assign proc_run  = run_lvl[0];
    assign bus_run   = run_lvl[1];
    assign board_run = run_lvl[2];
    assign irq_en    = run_lvl[3];
    assign force64   = f64_q;
    assign force32   = f32_q;

    a_r7_force_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(force64 && force32));
    a_r7_f32_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0] && wr_data[F32_BIT]) |=> (force32 && !force64));
    a_r9_lane3_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_be[3]) |=> $stable(run_lvl));
    a_r5_lane2_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_be[2]) |=> (dma_kick == '0));
endmodule

// File: tb/board_ctl_reg_test.sv
// Directed bench: one task per scenario, each checking its own results
// against a requirement model kept in the bench.
module board_ctl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        width_ok_in = 1'b1;
    logic [31:0] rd_data;
    logic        proc_run, bus_run, board_run, irq_en, force64, force32;
    logic [3:0]  dma_kick;
    logic [4:0]  dbell_cfg;

    int n_chk = 0;
    int n_bad = 0;

    // Requirement model.
    logic [3:0] m_run;   // 0 proc, 1 bus, 2 board, 3 irq
    logic       m_f64, m_f32;
    logic [4:0] m_cfg;
    logic [3:0] m_kick;

    always #2.5 clk = ~clk;

    board_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .width_ok_in(width_ok_in), .rd_data(rd_data),
        .proc_run(proc_run), .bus_run(bus_run), .board_run(board_run),
        .irq_en(irq_en), .dma_kick(dma_kick), .force64(force64),
        .force32(force32), .dbell_cfg(dbell_cfg)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++) begin
            v[31 - 2*k] = m_run[k];
            v[30 - 2*k] = ~m_run[k];
        end
        v[14] = width_ok_in;
        v[7]  = m_f64;
        v[6]  = m_f32;
        v[4:0] = m_cfg;
        return v;
    endfunction

    // Compare every output with the model.
    task automatic chk_all(input string req);
        chk(req, "run levels", {28'd0, irq_en, board_run, bus_run, proc_run},
            {28'd0, m_run});
        chk(req, "force", {30'd0, force64, force32}, {30'd0, m_f64, m_f32});
        chk(req, "cfg", {27'd0, dbell_cfg}, {27'd0, m_cfg});
        chk(req, "kick", {28'd0, dma_kick}, {28'd0, m_kick});
        chk(req, "rd_data", rd_data, model_rd());
    endtask

    // One write at a falling edge; model updated from the requirements;
    // outputs checked at the next falling edge, kick again one cycle on.
    task automatic do_write(input string req, input logic [3:0] be,
                            input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        if (be[3])
            for (int k = 0; k < 4; k++) begin
                if (d[30 - 2*k])      m_run[k] = 1'b0;
                else if (d[31 - 2*k]) m_run[k] = 1'b1;
            end
        m_kick = be[2] ? d[23:20] : 4'd0;
        if (be[0]) begin
            if (d[6])      begin m_f32 = 1'b1; m_f64 = 1'b0; end
            else if (d[7]) begin m_f64 = 1'b1; m_f32 = 1'b0; end
            m_cfg = d[4:0];
        end
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
        chk_all(req);
        m_kick = '0;
        @(negedge clk);
        chk(req, "kick after one cycle", {28'd0, dma_kick}, 32'd0);
    endtask

    task automatic t_reset();
        m_run = '0; m_f64 = 0; m_f32 = 0; m_cfg = '0; m_kick = '0;
        chk_all("R1");
        chk("R1", "reset word", rd_data, 32'h5500_4000);
    endtask

    task automatic t_pairs();
        do_write("R2", 4'b1000, 32'h0800_0000);   // board run
        do_write("R2", 4'b1000, 32'h2000_0000);   // bus run
        do_write("R2", 4'b1000, 32'h8000_0000);   // processor run
        do_write("R2", 4'b1000, 32'h0200_0000);   // irq enable
        chk("R2", "all running word", rd_data, 32'hAA00_4000);
        do_write("R2", 4'b1000, 32'h1000_0000);   // bus hold
        chk("R2", "bus held", {31'd0, bus_run}, 32'd0);
    endtask

    task automatic t_both();
        do_write("R3", 4'b1000, 32'hC000_0000);
        chk("R3", "proc clear wins", {31'd0, proc_run}, 32'd0);
        do_write("R3", 4'b1000, 32'h0300_0000);
        chk("R3", "irq disable wins", {31'd0, irq_en}, 32'd0);
        do_write("R2", 4'b1000, 32'hA200_0000);   // back to running
    endtask

    task automatic t_zero();
        do_write("R4", 4'b1111, 32'h0000_0000);
        chk("R4", "zeros keep levels", {31'd0, board_run}, 32'd1);
    endtask

    task automatic t_dma();
        @(negedge clk);
        wr_en = 1'b1; wr_be = 4'b0100; wr_data = 32'h0040_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
        chk("R5", "ch2 pulse", {28'd0, dma_kick}, 32'd4);
        chk("R10", "pulse in next cycle", {31'd0, dma_kick[2]}, 32'd1);
        @(negedge clk);
        chk("R5", "ch2 pulse gone", {28'd0, dma_kick}, 32'd0);
        do_write("R5", 4'b0100, 32'h00F0_0000);
        chk("R5", "trigger bits read zero", {28'd0, rd_data[23:20]}, 32'd0);
    endtask

    task automatic t_diag();
        do_write("R6", 4'b0011, 32'h0000_FE20);   // 13..9, 15, 14, 5
        chk("R6", "reserved bits zero", rd_data & 32'h0000_BF20, 32'd0);
        width_ok_in = 1'b0;
        @(negedge clk);
        chk("R6", "flag low", {31'd0, rd_data[14]}, 32'd0);
        chk_all("R6");
        width_ok_in = 1'b1;
    endtask

    task automatic t_force();
        do_write("R7", 4'b0001, 32'h0000_0080);
        chk("R7", "force64", {30'd0, force64, force32}, 32'd2);
        do_write("R7", 4'b0001, 32'h0000_0040);
        chk("R7", "force32", {30'd0, force64, force32}, 32'd1);
        do_write("R7", 4'b0001, 32'h0000_0080);
        do_write("R7", 4'b0001, 32'h0000_00C0);
        chk("R7", "force32 wins", {30'd0, force64, force32}, 32'd1);
    endtask

    task automatic t_cfg();
        do_write("R8", 4'b0001, 32'h0000_0015);
        chk("R8", "cfg written", {27'd0, dbell_cfg}, 32'h15);
        do_write("R9", 4'b1000, 32'h2000_0000);   // lane 0 off
        chk("R9", "cfg kept", {27'd0, dbell_cfg}, 32'h15);
        do_write("R8", 4'b0001, 32'h0000_000A);
        chk("R8", "cfg overwritten", {27'd0, dbell_cfg}, 32'h0A);
    endtask

    task automatic t_lanes();
        do_write("R9", 4'b0000, 32'hFFFF_FFFF);
        do_write("R9", 4'b0111, 32'h5500_0000);   // clears without lane 3
        chk("R9", "proc still runs", {31'd0, proc_run}, 32'd1);
    endtask

    initial begin : watchdog
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pairs();
        t_both();
        t_zero();
        t_dma();
        t_diag();
        t_force();
        t_cfg();
        t_lanes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule